// File: doc/BRIEF.md
# SDRAM Command Timing Gatekeeper

This block sits between the command generator of an SDRAM controller and the memory command bus. It watches every command that goes out and keeps per-bank and global timing windows. From these it reports, on every clock, which command may legally go to which bank. The block covers row activation, column read, column write, bank precharge and mode register load. Each command carries a two-bit bank number. A command that goes out before its window has closed, or that breaks the open/closed protocol of a bank, sets a sticky violation flag. A code records the cause of the first such event.

All timing limits are held in picoseconds. At elaboration each one becomes a cycle count: the limit divided by the clock period `CLK_PERIOD_PS`, rounded up. Write recovery takes one cycle only when the clock runs at or below 72 MHz and `FORCE_WR_TWO` is 0. Otherwise it takes two cycles, and forcing two cycles is the default. Only two configurations elaborate: a period of at least 7.5 ns with CAS latency 3, and a period of at least 9.5 ns with CAS latency 2. Any other configuration stops elaboration with an error.

The allowed outputs depend only on the state held in the block, not on the command presented in the same cycle. The controller reads them, picks a command, and drives it on `cmdOp`/`cmdBank`. The block treats whatever appears there as issued at the next rising edge.

Top module: `sdram_cmd_gate`

## Requirements
- R1: After a clock edge with `rstN` low, all banks are closed and every counter is zero. Reads out as `actAllowed`=4'hF, `rwAllowed`=0, `preAllowed`=4'hF, `mrsAllowed`=1, `violation`=0 and `violationCause`=0.
- R2: After an activate on a bank at cycle t, a read or write to that bank is allowed from cycle t+ceil(19 ns/period) on, and not before. At 7.5 ns this is t+3.
- R3: After an activate at cycle t, a new activate on the same bank is blocked until t+ceil(67 ns/period). After a precharge of an open bank at cycle p, an activate on that bank is also blocked until p+ceil(19 ns/period). At 7.5 ns these are 9 and 3 cycles.
- R4: After any activate at cycle t, an activate on any other bank is blocked until t+ceil(15 ns/period). One shared counter enforces this, giving 2 cycles at 7.5 ns.
- R5: Precharge of an open bank needs ceil(45 ns/period) cycles since its activate and the write recovery count since its last write. Write recovery is 1 cycle when `FORCE_WR_TWO`=0 and the clock is at most 72 MHz, and 2 cycles otherwise. Precharge of a closed bank is always allowed outside the mode-register window.
- R6: A mode register load at cycle t blocks every command on every bank through cycle t+1. All allowed outputs read zero in that window.
- R7: Commands are coded on `cmdOp` as 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 mode register load. Read and write are allowed only to an open bank, and activate only to a closed bank.
- R8: When an issued command is not allowed, `violation` rises one cycle later and stays high until reset. `violationCause` then holds the cause of the first event and ignores later ones. The cause codes are 1 for the mode-register window, 2 for a same-bank activate too early, 3 for a cross-bank activate too early, 4 for a read/write too early, 5 for a precharge before the minimum row time, 6 for a precharge inside write recovery, 7 for a row open too long, 8 for a read/write to a closed bank, and 9 for an activate to an open bank. For each command type, the mode-register window is checked first, then the protocol checks, then the timing checks.
- R9: A bank activated at cycle t may be precharged up to cycle t+ceil(100 us/period) while still open. If it is still open one cycle after that, the flag rises on the next edge with cause 7. At 7.5 ns the flag is 0 after 13335 edges from the activate and 1 after 13336.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous active-low reset |
| cmdOp | input | 3 | Command placed on the bus this cycle (code per R7) |
| cmdBank | input | 2 | Bank targeted by the command |
| actAllowed | output | 4 | Per bank: activate may issue now |
| rwAllowed | output | 4 | Per bank: read or write may issue now |
| preAllowed | output | 4 | Per bank: precharge may issue now |
| mrsAllowed | output | 1 | Mode register load may issue now |
| violation | output | 1 | Sticky flag for an illegal command or overlong row |
| violationCause | output | 4 | Cause of the first violation (code per R8) |

## Verification
The bench builds two instances. The first uses the default 7.5 ns period with CAS latency 3 and forced two-cycle write recovery. This gives multi-cycle windows of 2, 3, 6 and 9 cycles, so every early and just-in-time edge can be probed, and the 13334-cycle row limit can be reached. The second uses a 15 ns period with CAS latency 2 and the forcing turned off. This selects the single-cycle write recovery path, which shows up as a precharge allowed one cycle after a write.

// File: rtl/sdram_gate_pkg.sv
`timescale 1ns/1ps
package sdram_gate_pkg;

  localparam int BANK_COUNT = 4;
  localparam int BANK_BITS  = $clog2(BANK_COUNT);

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_ACT   = 3'd1,
    OP_READ  = 3'd2,
    OP_WRITE = 3'd3,
    OP_PRE   = 3'd4,
    OP_MRS   = 3'd5
  } cmdOpE;

  typedef enum logic [3:0] {
    CAUSE_NONE      = 4'd0,
    CAUSE_MRD       = 4'd1,
    CAUSE_ACT_SAME  = 4'd2,
    CAUSE_ACT_CROSS = 4'd3,
    CAUSE_RCD       = 4'd4,
    CAUSE_RAS_MIN   = 4'd5,
    CAUSE_WR_REC    = 4'd6,
    CAUSE_RAS_MAX   = 4'd7,
    CAUSE_RW_CLOSED = 4'd8,
    CAUSE_ACT_OPEN  = 4'd9
  } causeE;

  // control -> datapath: one-hot bank strobes per issued command
  typedef struct packed {
    logic [BANK_COUNT-1:0] act;
    logic [BANK_COUNT-1:0] rd;
    logic [BANK_COUNT-1:0] wr;
    logic [BANK_COUNT-1:0] pre;
    logic                  mrs;
  } strobeT;

  // datapath -> control: window status
  typedef struct packed {
    logic [BANK_COUNT-1:0] open;
    logic [BANK_COUNT-1:0] rcClear;
    logic [BANK_COUNT-1:0] rpClear;
    logic [BANK_COUNT-1:0] rcdClear;
    logic [BANK_COUNT-1:0] rasClear;
    logic [BANK_COUNT-1:0] wrClear;
    logic [BANK_COUNT-1:0] rasOver;
    logic                  rrdClear;
    logic                  mrdClear;
  } timerStatT;

  function automatic int cyclesFor(int limitPs, int periodPs);
    return (limitPs + periodPs - 1) / periodPs;
  endfunction

  function automatic int maxInt(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_gate_timers.sv
`timescale 1ns/1ps
module sdram_gate_timers
  import sdram_gate_pkg::*;
#(
  parameter int RC_CYC     = 9,
  parameter int RCD_CYC    = 3,
  parameter int RRD_CYC    = 2,
  parameter int RAS_CYC    = 6,
  parameter int RP_CYC     = 3,
  parameter int WR_CYC     = 2,
  parameter int MRD_CYC    = 2,
  parameter int RASMAX_CYC = 13334
) (
  input  logic      clk,
  input  logic      rstN,
  input  strobeT    strobe,
  output timerStatT stat
);

  localparam int SHORT_MAX = maxInt(maxInt(maxInt(RC_CYC, RCD_CYC), maxInt(RRD_CYC, RAS_CYC)),
                                    maxInt(maxInt(RP_CYC, WR_CYC), MRD_CYC));
  localparam int CW = $clog2(SHORT_MAX + 1);
  localparam int AW = $clog2(RASMAX_CYC + 2);

  typedef logic [CW-1:0] shortT;
  typedef logic [AW-1:0] ageT;

  localparam shortT RC_LD  = shortT'(RC_CYC - 1);
  localparam shortT RCD_LD = shortT'(RCD_CYC - 1);
  localparam shortT RRD_LD = shortT'(RRD_CYC - 1);
  localparam shortT RAS_LD = shortT'(RAS_CYC - 1);
  localparam shortT RP_LD  = shortT'(RP_CYC - 1);
  localparam shortT WR_LD  = shortT'(WR_CYC - 1);
  localparam shortT MRD_LD = shortT'(MRD_CYC - 1);
  localparam ageT   AGE_LIMIT = ageT'(RASMAX_CYC);

  function automatic shortT stepDown(shortT v);
    return (v == '0) ? '0 : shortT'(v - 1'b1);
  endfunction

  logic [BANK_COUNT-1:0] openV, rcClr, rpClr, rcdClr, rasClr, wrClr, overV;
  shortT rrdCnt, mrdCnt;

  for (genvar b = 0; b < BANK_COUNT; b++) begin : g_bank
    shortT rcCnt, rcdCnt, rasCnt, rpCnt, wrCnt;
    ageT   age;
    logic  isOpen;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        rcCnt  <= '0;
        rcdCnt <= '0;
        rasCnt <= '0;
        rpCnt  <= '0;
        wrCnt  <= '0;
        age    <= '0;
        isOpen <= 1'b0;
      end else begin
        rcCnt  <= strobe.act[b] ? RC_LD  : stepDown(rcCnt);
        rcdCnt <= strobe.act[b] ? RCD_LD : stepDown(rcdCnt);
        rasCnt <= strobe.act[b] ? RAS_LD : stepDown(rasCnt);
        rpCnt  <= (strobe.pre[b] && isOpen) ? RP_LD : stepDown(rpCnt);
        wrCnt  <= strobe.wr[b] ? WR_LD : stepDown(wrCnt);
        if (strobe.act[b]) begin
          isOpen <= 1'b1;
          age    <= ageT'(1);
        end else if (strobe.pre[b]) begin
          isOpen <= 1'b0;
          age    <= '0;
        end else if (isOpen && age <= AGE_LIMIT) begin
          age <= ageT'(age + 1'b1);
        end
      end
    end

    assign openV[b]  = isOpen;
    assign rcClr[b]  = (rcCnt == '0);
    assign rpClr[b]  = (rpCnt == '0);
    assign rcdClr[b] = (rcdCnt == '0);
    assign rasClr[b] = (rasCnt == '0);
    assign wrClr[b]  = (wrCnt == '0);
    assign overV[b]  = isOpen && (age > AGE_LIMIT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrdCnt <= '0;
      mrdCnt <= '0;
    end else begin
      rrdCnt <= (|strobe.act) ? RRD_LD : stepDown(rrdCnt);
      mrdCnt <= strobe.mrs ? MRD_LD : stepDown(mrdCnt);
    end
  end

  always_comb begin
    stat.open     = openV;
    stat.rcClear  = rcClr;
    stat.rpClear  = rpClr;
    stat.rcdClear = rcdClr;
    stat.rasClear = rasClr;
    stat.wrClear  = wrClr;
    stat.rasOver  = overV;
    stat.rrdClear = (rrdCnt == '0);
    stat.mrdClear = (mrdCnt == '0);
  end

endmodule

// File: rtl/sdram_gate_ctrl.sv
`timescale 1ns/1ps
module sdram_gate_ctrl
  import sdram_gate_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [2:0]            cmdOp,
  input  logic [BANK_BITS-1:0]  cmdBank,
  input  timerStatT             stat,
  output strobeT                strobe,
  output logic [BANK_COUNT-1:0] actAllowed,
  output logic [BANK_COUNT-1:0] rwAllowed,
  output logic [BANK_COUNT-1:0] preAllowed,
  output logic                  mrsAllowed,
  output logic                  violation,
  output logic [3:0]            violationCause
);

  cmdOpE                 op;
  logic [BANK_COUNT-1:0] bankSel;
  causeE                 cause;
  causeE                 causeQ;

  assign op      = cmdOpE'(cmdOp);
  assign bankSel = BANK_COUNT'(1) << cmdBank;

  always_comb begin
    strobe.act = (op == OP_ACT)   ? bankSel : '0;
    strobe.rd  = (op == OP_READ)  ? bankSel : '0;
    strobe.wr  = (op == OP_WRITE) ? bankSel : '0;
    strobe.pre = (op == OP_PRE)   ? bankSel : '0;
    strobe.mrs = (op == OP_MRS);
  end

  always_comb begin
    for (int b = 0; b < BANK_COUNT; b++) begin
      actAllowed[b] = stat.mrdClear && !stat.open[b] && stat.rcClear[b]
                      && stat.rpClear[b] && stat.rrdClear;
      rwAllowed[b]  = stat.mrdClear && stat.open[b] && stat.rcdClear[b];
      preAllowed[b] = stat.mrdClear
                      && (!stat.open[b] || (stat.rasClear[b] && stat.wrClear[b]));
    end
    mrsAllowed = stat.mrdClear;
  end

  // cause of this cycle's event; mode window first, then protocol, then timing
  always_comb begin
    cause = CAUSE_NONE;
    unique case (op)
      OP_ACT: begin
        if (!stat.mrdClear)                                        cause = CAUSE_MRD;
        else if (stat.open[cmdBank])                               cause = CAUSE_ACT_OPEN;
        else if (!stat.rcClear[cmdBank] || !stat.rpClear[cmdBank]) cause = CAUSE_ACT_SAME;
        else if (!stat.rrdClear)                                   cause = CAUSE_ACT_CROSS;
      end
      OP_READ, OP_WRITE: begin
        if (!stat.mrdClear)                 cause = CAUSE_MRD;
        else if (!stat.open[cmdBank])       cause = CAUSE_RW_CLOSED;
        else if (!stat.rcdClear[cmdBank])   cause = CAUSE_RCD;
      end
      OP_PRE: begin
        if (!stat.mrdClear)                 cause = CAUSE_MRD;
        else if (stat.open[cmdBank]) begin
          if (!stat.rasClear[cmdBank])      cause = CAUSE_RAS_MIN;
          else if (!stat.wrClear[cmdBank])  cause = CAUSE_WR_REC;
        end
      end
      OP_MRS: begin
        if (!stat.mrdClear)                 cause = CAUSE_MRD;
      end
      default: cause = CAUSE_NONE;
    endcase
    if (cause == CAUSE_NONE && (|stat.rasOver)) cause = CAUSE_RAS_MAX;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      violation <= 1'b0;
      causeQ    <= CAUSE_NONE;
    end else if (!violation && cause != CAUSE_NONE) begin
      violation <= 1'b1;
      causeQ    <= cause;
    end
  end

  assign violationCause = causeQ;

endmodule

// File: rtl/sdram_cmd_gate.sv
`timescale 1ns/1ps
module sdram_cmd_gate
  import sdram_gate_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 7500,
  parameter int CAS_LATENCY   = 3,
  parameter bit FORCE_WR_TWO  = 1'b1,
  parameter int RAS_MAX_PS    = 100_000_000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [2:0]            cmdOp,
  input  logic [BANK_BITS-1:0]  cmdBank,
  output logic [BANK_COUNT-1:0] actAllowed,
  output logic [BANK_COUNT-1:0] rwAllowed,
  output logic [BANK_COUNT-1:0] preAllowed,
  output logic                  mrsAllowed,
  output logic                  violation,
  output logic [3:0]            violationCause
);

  localparam int RC_CYC     = cyclesFor(67_000, CLK_PERIOD_PS);
  localparam int RCD_CYC    = cyclesFor(19_000, CLK_PERIOD_PS);
  localparam int RRD_CYC    = cyclesFor(15_000, CLK_PERIOD_PS);
  localparam int RAS_CYC    = cyclesFor(45_000, CLK_PERIOD_PS);
  localparam int RP_CYC     = cyclesFor(19_000, CLK_PERIOD_PS);
  localparam int RASMAX_CYC = cyclesFor(RAS_MAX_PS, CLK_PERIOD_PS);
  localparam bit SLOW_CLK   = (CLK_PERIOD_PS * 72) >= 1_000_000;
  localparam int WR_CYC     = (!FORCE_WR_TWO && SLOW_CLK) ? 1 : 2;
  localparam int MRD_CYC    = 2;
  localparam bit CFG_OK     = (CAS_LATENCY == 3 && CLK_PERIOD_PS >= 7500)
                            || (CAS_LATENCY == 2 && CLK_PERIOD_PS >= 9500);

  if (!CFG_OK) begin : g_badCfg
    $error("sdram_cmd_gate: clock period too short for the chosen CAS latency");
  end

  strobeT    strobe;
  timerStatT stat;

  sdram_gate_ctrl i_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .cmdOp          (cmdOp),
    .cmdBank        (cmdBank),
    .stat           (stat),
    .strobe         (strobe),
    .actAllowed     (actAllowed),
    .rwAllowed      (rwAllowed),
    .preAllowed     (preAllowed),
    .mrsAllowed     (mrsAllowed),
    .violation      (violation),
    .violationCause (violationCause)
  );

  sdram_gate_timers #(
    .RC_CYC     (RC_CYC),
    .RCD_CYC    (RCD_CYC),
    .RRD_CYC    (RRD_CYC),
    .RAS_CYC    (RAS_CYC),
    .RP_CYC     (RP_CYC),
    .WR_CYC     (WR_CYC),
    .MRD_CYC    (MRD_CYC),
    .RASMAX_CYC (RASMAX_CYC)
  ) i_timers (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .stat   (stat)
  );

endmodule

// File: rtl/sdram_gate_chk.sv
`timescale 1ns/1ps
module sdram_gate_chk
  import sdram_gate_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic [2:0]            cmdOp,
  input logic [BANK_BITS-1:0]  cmdBank,
  input logic [BANK_COUNT-1:0] actAllowed,
  input logic [BANK_COUNT-1:0] rwAllowed,
  input logic [BANK_COUNT-1:0] preAllowed,
  input logic                  mrsAllowed,
  input logic                  violation,
  input logic [3:0]            violationCause
);

  assert_mrs_blocks_all_R6: assert property (@(posedge clk) disable iff (!rstN)
    cmdOp == OP_MRS |=> (actAllowed == '0 && rwAllowed == '0 && preAllowed == '0 && !mrsAllowed));

  assert_act_holds_pre_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmdOp == OP_ACT |=> !preAllowed[$past(cmdBank)]);

  assert_act_blocks_same_bank_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmdOp == OP_ACT |=> !actAllowed[$past(cmdBank)]);

  assert_open_closed_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    (actAllowed & rwAllowed) == '0);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    violation |=> (violation && violationCause == $past(violationCause)));

endmodule

bind sdram_cmd_gate sdram_gate_chk i_chk (.*);

// File: tb/test_sdram_cmd_gate.sv
`timescale 1ns/1ps
module test_sdram_cmd_gate;
  import sdram_gate_pkg::*;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] cmdOp = 3'd0;
  logic [1:0] cmdBank = 2'd0;
  logic [3:0] actAllowed, rwAllowed, preAllowed;
  logic       mrsAllowed, violation;
  logic [3:0] violationCause;

  logic [2:0] sCmdOp = 3'd0;
  logic [1:0] sCmdBank = 2'd0;
  logic [3:0] sAct, sRw, sPre;
  logic       sMrs, sViol;
  logic [3:0] sCause;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  sdram_cmd_gate i_sdram_cmd_gate (
    .clk(clk), .rstN(rstN), .cmdOp(cmdOp), .cmdBank(cmdBank),
    .actAllowed(actAllowed), .rwAllowed(rwAllowed), .preAllowed(preAllowed),
    .mrsAllowed(mrsAllowed), .violation(violation), .violationCause(violationCause)
  );

  sdram_cmd_gate #(.CLK_PERIOD_PS(15000), .CAS_LATENCY(2), .FORCE_WR_TWO(1'b0)) i_slowGate (
    .clk(clk), .rstN(rstN), .cmdOp(sCmdOp), .cmdBank(sCmdBank),
    .actAllowed(sAct), .rwAllowed(sRw), .preAllowed(sPre),
    .mrsAllowed(sMrs), .violation(sViol), .violationCause(sCause)
  );

  typedef struct packed {
    logic [2:0] op;
    logic [1:0] bank;
    logic       issue;
    logic       exp;
  } vecT;

  localparam int NVEC = 15;
  localparam vecT VECS [NVEC] = '{
    '{3'd1, 2'd0, 1'b1, 1'b1},  // c0  ACT b0
    '{3'd1, 2'd1, 1'b0, 1'b0},  // c1  ACT b1 inside cross-bank window
    '{3'd1, 2'd1, 1'b1, 1'b1},  // c2  ACT b1
    '{3'd2, 2'd0, 1'b1, 1'b1},  // c3  READ b0 exactly at +3
    '{3'd2, 2'd1, 1'b0, 1'b0},  // c4  READ b1 at +2 too early
    '{3'd3, 2'd1, 1'b1, 1'b1},  // c5  WRITE b1
    '{3'd4, 2'd0, 1'b1, 1'b1},  // c6  PRE b0 exactly at +6
    '{3'd1, 2'd0, 1'b0, 1'b0},  // c7  ACT b0 during precharge window
    '{3'd4, 2'd1, 1'b0, 1'b1},  // c8  PRE b1 probe, all clear
    '{3'd1, 2'd0, 1'b1, 1'b1},  // c9  ACT b0 at +9 / +3
    '{3'd2, 2'd0, 1'b0, 1'b0},  // c10 READ b0 too early
    '{3'd5, 2'd0, 1'b1, 1'b1},  // c11 MRS
    '{3'd4, 2'd1, 1'b0, 1'b0},  // c12 PRE b1 in mode window
    '{3'd4, 2'd1, 1'b1, 1'b1},  // c13 PRE b1
    '{3'd2, 2'd1, 1'b0, 1'b0}   // c14 READ b1 now closed
  };

  function automatic logic allowedFor(logic [2:0] op, logic [1:0] bank);
    case (op)
      3'd1:       return actAllowed[bank];
      3'd2, 3'd3: return rwAllowed[bank];
      3'd4:       return preAllowed[bank];
      3'd5:       return mrsAllowed;
      default:    return 1'b1;
    endcase
  endfunction

  function automatic string tagFor(logic [2:0] op);
    case (op)
      3'd1:       return "R3";
      3'd2, 3'd3: return "R2";
      3'd4:       return "R5";
      default:    return "R6";
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; cmdOp = 3'd0; sCmdOp = 3'd0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic drive(logic [2:0] op, logic [1:0] bank);
    cmdOp = op; cmdBank = bank;
    @(negedge clk);
    cmdOp = 3'd0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    doReset();
    // R1 reset state
    check("R1 act", actAllowed, 16'hF);
    check("R1 rw", rwAllowed, 16'h0);
    check("R1 pre", preAllowed, 16'hF);
    check("R1 mrs/viol/cause", {mrsAllowed, violation, violationCause}, {1'b1, 1'b0, 4'd0});

    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      check(tagFor(VECS[k].op), allowedFor(VECS[k].op, VECS[k].bank), VECS[k].exp);
      cmdOp   = VECS[k].issue ? VECS[k].op : 3'd0;
      cmdBank = VECS[k].bank;
    end
    @(negedge clk);
    cmdOp = 3'd0;
    check("R8 no flag after legal run", violation, 1'b0);

    // R5 write recovery holds precharge after the minimum row time
    doReset();
    drive(3'd1, 2'd2);
    idle(4);
    check("R2 rw at +5", rwAllowed[2], 1'b1);
    drive(3'd3, 2'd2);
    check("R5 pre inside write recovery", preAllowed[2], 1'b0);
    idle(1);
    check("R5 pre after write recovery", preAllowed[2], 1'b1);

    // R7/R8 read to closed bank, later violation ignored
    drive(3'd2, 2'd3);
    check("R7 rw closed cause", {violation, violationCause}, {1'b1, 4'd8});
    drive(3'd1, 2'd2);
    check("R8 sticky first cause", {violation, violationCause}, {1'b1, 4'd8});

    // R4 cross-bank activate too early
    doReset();
    drive(3'd1, 2'd0);
    drive(3'd1, 2'd1);
    check("R4 cross act cause", {violation, violationCause}, {1'b1, 4'd3});

    // R7 activate to open bank wins over timing
    doReset();
    drive(3'd1, 2'd0);
    drive(3'd1, 2'd0);
    check("R7 act open cause", {violation, violationCause}, {1'b1, 4'd9});

    // R6 mode register window
    doReset();
    drive(3'd5, 2'd0);
    check("R6 window blocks", {mrsAllowed, actAllowed, preAllowed}, 9'd0);
    drive(3'd1, 2'd0);
    check("R6 act in window cause", {violation, violationCause}, {1'b1, 4'd1});

    // slow variant: single-cycle write recovery (R5)
    doReset();
    sCmdOp = 3'd1; sCmdBank = 2'd0;
    @(negedge clk);
    sCmdOp = 3'd0;
    check("R2 slow rw at +1", sRw[0], 1'b0);
    @(negedge clk);
    check("R2 slow rw at +2", sRw[0], 1'b1);
    sCmdOp = 3'd3;
    @(negedge clk);
    sCmdOp = 3'd0;
    check("R5 slow pre one cycle after write", sPre[0], 1'b1);
    check("R8 slow no flag", sViol, 1'b0);

    // R9 row left open too long
    doReset();
    drive(3'd1, 2'd0);
    idle(13334);
    check("R9 at limit", violation, 1'b0);
    idle(1);
    check("R9 past limit", {violation, violationCause}, {1'b1, 4'd7});

    finishRun();
  end

endmodule